// File: doc/BRIEF.md
# Stereo Audio Serial Controller with FIFO Watermark Interrupts

This block connects a register bus to a stereo audio codec. Software writes 32-bit stereo words into a small transmit FIFO and reads captured words from a receive FIFO. Each word holds the left sample in bits [31:16] and the right sample in bits [15:0]. The controller generates the bit clock and the left/right frame clock itself. It shifts transmit frames out MSB first and assembles receive frames from the serial input.

The control register enables each direction and its interrupt. It also sets a watermark for each FIFO, can hold both FIFOs empty, and can drive the codec reset pin. The transmit alert is raised while the transmit FIFO has more free entries than its watermark. The receive alert is raised while the receive FIFO has fewer free entries than its watermark. The interrupt line combines each alert with its enable. Overrun and underrun events set sticky error flags. Software clears a flag by writing a one to the matching bit of the error offset.

The serial timing comes from a three-state machine:
- `ENG_IDLE`: clocks parked low, entered whenever both directions are disabled.
- `ENG_BCLK_LO`: bit clock low.
- `ENG_BCLK_HI`: bit clock high.

The transitions are:
- *start*: IDLE to LO when either direction is enabled. The first frame is loaded and the bit index is zero.
- *rise*: LO to HI after the half period. The serial input is sampled.
- *fall*: HI to LO after the half period. The next bit is shifted out; after bit 31 this is the frame boundary, where the receive word is pushed and the next transmit word is loaded.
- *stop*: LO or HI to IDLE as soon as both directions are disabled. The partial frame is dropped.

Top module: `audio_stream_ctrl`

## Requirements
- R1: After reset, the status register (word offset 0x04) reads 0x15, the divide register (0x0C) reads 0x80, the error register (0x08) reads 0, and the bit clock, frame clock, interrupt and codec reset outputs are all low.
- R2: The status register reports FIFO occupancy as follows: bit 2 is set when the transmit FIFO is empty, bit 3 when it is full (4 words), bit 4 when the receive FIFO is empty, and bit 5 when it is full.
- R3: Status bit 0 (the transmit alert) is high while the free entries in the transmit FIFO exceed the watermark held in control bits [10:8].
- R4: Status bit 1 (the receive alert) is high while the free entries in the receive FIFO are fewer than the watermark held in control bits [14:12].
- R5: `irq_o` is high exactly when (the transmit alert and control bit 1) or (the receive alert and control bit 3) hold.
- R6: A write to the transmit buffer (0x10) while that FIFO is full is dropped and sets error bit 0. A read of the receive buffer (0x14) while that FIFO is empty sets error bit 1. Both error flags stay set until a one is written to the same bit at offset 0x08.
- R7: With transmit enabled (control bit 0), a frame that starts while the transmit FIFO is empty sends 32 zero bits and sets error bit 0.
- R8: With receive enabled (control bit 2), a frame that completes while the receive FIFO is full is discarded and sets error bit 1.
- R9: Each frame is 32 bit clocks long and is sent MSB first. The frame clock is low for bits [31:16] (left) and high for bits [15:0] (right). Output data changes only on a falling bit-clock edge and input is sampled on the rising edge, so a looped-back output reproduces the transmitted words in order.
- R10: Each bit-clock phase (high or low) lasts DIV system cycles, where DIV is the divide register [9:0] and a value of 0 acts as 1.
- R11: While control bit 16 is set, both FIFOs are held empty and transmit-buffer writes have no effect. Control bit 17 drives `codec_rst_o`.
- R12: When both control bits 0 and 2 are clear, the bit clock and frame clock return low within one cycle and stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of 0x14 pops the receive FIFO |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ser_din | input | 1 | Serial data from the codec |
| ser_dout | output | 1 | Serial data to the codec |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Left/right frame clock |
| irq_o | output | 1 | Combined alert interrupt |
| codec_rst_o | output | 1 | Codec reset drive |

## Verification
- **Register writes and FIFO accesses** take effect at the clock edge that captures the strobe. Status, error and interrupt outputs are read back half a cycle later.
- **Enabling the engine** moves it out of IDLE on the following edge. A frame then lasts 64×DIV cycles, and its receive word is pushed on the falling bit-clock edge that ends bit 31.
- **Frame-count checks** wait a number of cycles chosen mid-way between frame boundaries, so an off-by-one in the engine's timing cannot change the count of pushed words.
- **Serial bits** are taken one delta after each rising bit-clock edge.
- **Clock phase lengths** are counted on falling system-clock edges.

// File: rtl/audio_pkg.sv
package audio_pkg;

    // Register word indices (byte offset / 4)
    localparam int REG_CTRL  = 0;
    localparam int REG_STAT  = 1;
    localparam int REG_ERR   = 2;
    localparam int REG_DIV   = 3;
    localparam int REG_TXBUF = 4;
    localparam int REG_RXBUF = 5;

    // Control field positions
    localparam int CB_TX_EN    = 0;
    localparam int CB_TX_IE    = 1;
    localparam int CB_RX_EN    = 2;
    localparam int CB_RX_IE    = 3;
    localparam int CB_TX_WM    = 8;
    localparam int CB_RX_WM    = 12;
    localparam int CB_FIFO_RST = 16;
    localparam int CB_CODEC    = 17;
    localparam int WM_W        = 3;

    typedef enum logic [1:0] {
        ENG_IDLE    = 2'd0,
        ENG_BCLK_LO = 2'd1,
        ENG_BCLK_HI = 2'd2
    } eng_state_e;

endpackage

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic [WIDTH-1:0]               din,
    input  logic                           pop,
    output logic [WIDTH-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count_q;
    logic do_push, do_pop;

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign count   = count_q;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr == PTR_W'(i)) mem[i] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else if (clr) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) wr_ptr <= wrap_inc(wr_ptr);
            if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // R2: a push into a full FIFO leaves it full, never wraps
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> full);

endmodule

// File: rtl/audio_bit_engine.sv
module audio_bit_engine
    import audio_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DIV_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_avail,
    output logic              tx_pop,
    output logic              tx_underrun,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              bclk,
    output logic              lrclk,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_push
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    eng_state_e state_q, state_d;
    logic [DIV_W-1:0]  cnt_q, lim;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic run, expire, ev_start, ev_rise, ev_fall, frame_end, load;

    assign run       = tx_en || rx_en;
    assign lim       = (half_div == '0) ? DIV_W'(1) : half_div;
    assign expire    = (cnt_q == lim - DIV_W'(1));
    assign frame_end = ev_fall && (bit_q == LAST_BIT);
    assign load      = ev_start || frame_end;

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        ev_start = 1'b0;
        ev_rise  = 1'b0;
        ev_fall  = 1'b0;
        unique case (state_q)
            ENG_IDLE: begin
                if (run) begin
                    state_d  = ENG_BCLK_LO;
                    ev_start = 1'b1;
                end
            end
            ENG_BCLK_LO: begin
                if (!run) state_d = ENG_IDLE;
                else if (expire) begin
                    state_d = ENG_BCLK_HI;
                    ev_rise = 1'b1;
                end
            end
            ENG_BCLK_HI: begin
                if (!run) state_d = ENG_IDLE;
                else if (expire) begin
                    state_d = ENG_BCLK_LO;
                    ev_fall = 1'b1;
                end
            end
            default: state_d = ENG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bit_q <= '0;
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (state_d != state_q || state_q == ENG_IDLE) cnt_q <= '0;
            else                                          cnt_q <= cnt_q + DIV_W'(1);

            if (state_d == ENG_IDLE || frame_end) bit_q <= '0;
            else if (ev_fall)                     bit_q <= bit_q + BIT_W'(1);

            if (load)         tx_sh <= (tx_en && tx_avail) ? tx_word : '0;
            else if (ev_fall) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};

            if (ev_rise) rx_sh <= {rx_sh[WORD_W-2:0], ser_din};
        end
    end

    // Outputs
    always_comb begin
        tx_pop      = load && tx_en && tx_avail;
        tx_underrun = load && tx_en && !tx_avail;
        rx_push     = frame_end && rx_en;
        rx_word     = rx_sh;
        bclk        = (state_q == ENG_BCLK_HI);
        lrclk       = bit_q[BIT_W-1];
        ser_dout    = tx_sh[WORD_W-1];
    end

    // R12: disabling both directions parks the bit clock low next cycle
    p_bclk_park_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bclk);

    // R9: while running, the frame clock only moves on a falling bit clock
    p_lr_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ENG_IDLE && !$stable(lrclk)) |-> $fell(bclk));

endmodule

// File: rtl/audio_stream_ctrl.sv
module audio_stream_ctrl
    import audio_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int SAMPLE_W   = 16,
    parameter int DIV_W      = 10,
    parameter int ADDR_W     = 5,
    parameter int DIV_RESET  = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [2*SAMPLE_W-1:0] bus_wdata,
    output logic [2*SAMPLE_W-1:0] bus_rdata,
    input  logic                  ser_din,
    output logic                  ser_dout,
    output logic                  bclk_o,
    output logic                  lrclk_o,
    output logic                  irq_o,
    output logic                  codec_rst_o
);
    localparam int WORD_W = 2 * SAMPLE_W;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int FREE_W = 8;
    localparam logic [WORD_W-1:0] CTRL_MASK =
        WORD_W'((1 << CB_TX_EN) | (1 << CB_TX_IE) | (1 << CB_RX_EN) | (1 << CB_RX_IE) |
                (7 << CB_TX_WM) | (7 << CB_RX_WM) | (1 << CB_FIFO_RST) | (1 << CB_CODEC));

    logic [WORD_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [1:0]        err_q;
    logic [IDX_W-1:0]  idx;
    logic              unused_addr_lsb;

    logic tx_en, rx_en, fifo_rst;
    logic [WM_W-1:0] tx_wm, rx_wm;

    logic wr_ctrl, wr_err, wr_div, wr_tx, rd_rx;
    logic tx_push, tx_ovr, rx_pop, rx_udr;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic eng_pop, eng_udr, eng_frame, rx_fifo_push, rx_ovr;
    logic [FREE_W-1:0] tx_free, rx_free;
    logic tx_alert, rx_alert;

    assign idx             = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];

    assign tx_en    = ctrl_q[CB_TX_EN];
    assign rx_en    = ctrl_q[CB_RX_EN];
    assign fifo_rst = ctrl_q[CB_FIFO_RST];
    assign tx_wm    = ctrl_q[CB_TX_WM +: WM_W];
    assign rx_wm    = ctrl_q[CB_RX_WM +: WM_W];

    // Bus decode
    assign wr_ctrl = bus_wr && idx == IDX_W'(REG_CTRL);
    assign wr_err  = bus_wr && idx == IDX_W'(REG_ERR);
    assign wr_div  = bus_wr && idx == IDX_W'(REG_DIV);
    assign wr_tx   = bus_wr && idx == IDX_W'(REG_TXBUF);
    assign rd_rx   = bus_rd && idx == IDX_W'(REG_RXBUF);

    assign tx_push = wr_tx && !fifo_rst && !tx_full;
    assign tx_ovr  = wr_tx && !fifo_rst && tx_full;
    assign rx_pop  = rd_rx && !rx_empty;
    assign rx_udr  = rd_rx && rx_empty;

    assign rx_fifo_push = eng_frame && !rx_full;
    assign rx_ovr       = eng_frame && rx_full;

    // Watermark comparisons on free space
    assign tx_free  = FREE_W'(FIFO_DEPTH) - FREE_W'(tx_count);
    assign rx_free  = FREE_W'(FIFO_DEPTH) - FREE_W'(rx_count);
    assign tx_alert = tx_free > FREE_W'(tx_wm);
    assign rx_alert = rx_free < FREE_W'(rx_wm);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= DIV_W'(DIV_RESET);
            err_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
            if (wr_div)  div_q  <= bus_wdata[DIV_W-1:0];
            err_q[0] <= (err_q[0] && !(wr_err && bus_wdata[0])) || tx_ovr || eng_udr;
            err_q[1] <= (err_q[1] && !(wr_err && bus_wdata[1])) || rx_udr || rx_ovr;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_W'(REG_CTRL):  bus_rdata = ctrl_q;
            IDX_W'(REG_STAT):  bus_rdata = WORD_W'({rx_full, rx_empty, tx_full, tx_empty,
                                                    rx_alert, tx_alert});
            IDX_W'(REG_ERR):   bus_rdata = WORD_W'(err_q);
            IDX_W'(REG_DIV):   bus_rdata = WORD_W'(div_q);
            IDX_W'(REG_RXBUF): bus_rdata = rx_empty ? '0 : rx_head;
            default:           bus_rdata = '0;
        endcase
    end

    assign irq_o       = (tx_alert && ctrl_q[CB_TX_IE]) || (rx_alert && ctrl_q[CB_RX_IE]);
    assign codec_rst_o = ctrl_q[CB_CODEC];

    audio_sample_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_rst),
        .push(tx_push), .din(bus_wdata), .pop(eng_pop),
        .dout(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    audio_sample_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_rst),
        .push(rx_fifo_push), .din(rx_word), .pop(rx_pop),
        .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    audio_bit_engine #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .half_div(div_q), .tx_word(tx_head), .tx_avail(!tx_empty),
        .tx_pop(eng_pop), .tx_underrun(eng_udr),
        .ser_din(ser_din), .ser_dout(ser_dout),
        .bclk(bclk_o), .lrclk(lrclk_o),
        .rx_word(rx_word), .rx_push(eng_frame)
    );

    // R6: error flags hold until written with one at the error offset
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q[1] && !(wr_err && bus_wdata[1])) |=> err_q[1]);

    // R7: a transmit frame started on an empty FIFO flags bit 0
    p_underrun_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_udr |=> err_q[0]);

    // R8: a completed frame into a full receive FIFO leaves occupancy unchanged
    p_overrun_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_frame && rx_full && !rx_pop && !fifo_rst) |=> (rx_count == $past(rx_count)));

    // R11: FIFO hold keeps the transmit FIFO empty
    p_fifo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst |=> tx_empty);

endmodule

// File: tb/test_audio_stream_ctrl.sv
module test_audio_stream_ctrl;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_dout, bclk_o, lrclk_o, irq_o, codec_rst_o;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    audio_stream_ctrl i_audio_stream_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_din(ser_dout), .ser_dout(ser_dout), .bclk_o(bclk_o),
        .lrclk_o(lrclk_o), .irq_o(irq_o), .codec_rst_o(codec_rst_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clean_up();
        wr(5'h00, 32'h0001_0000);
        wr(5'h00, 32'h0);
        wr(5'h08, 32'h3);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(5'h04, d); check("R1 status", d, 32'h15);
        rd(5'h0C, d); check("R1 divide", d, 32'h80);
        rd(5'h08, d); check("R1 error", d, 32'h0);
        check("R1 pins", {28'h0, bclk_o, lrclk_o, irq_o, codec_rst_o}, 32'h0);
    endtask

    task automatic t_watermarks();
        logic [31:0] d;
        wr(5'h00, 32'h0000_0102);  // tx wm 1, tx irq enable
        rd(5'h04, d); check("R3 alert empty", d & 32'h1, 32'h1);
        check("R5 irq tx", {31'h0, irq_o}, 32'h1);
        for (int i = 0; i < 3; i++) wr(5'h10, 32'h100 + i);
        rd(5'h04, d); check("R3 alert 1 free", d & 32'h1, 32'h0);
        check("R5 irq low", {31'h0, irq_o}, 32'h0);
        check("R2 tx partial", d & 32'h0C, 32'h0);
        wr(5'h10, 32'h200);
        rd(5'h04, d); check("R2 tx full", d & 32'h0C, 32'h8);
        wr(5'h10, 32'h300);
        rd(5'h08, d); check("R6 tx overrun", d, 32'h1);
        wr(5'h08, 32'h1);
        rd(5'h08, d); check("R6 w1c tx", d, 32'h0);
        wr(5'h00, 32'h0001_0102);
        wr(5'h10, 32'h400);
        rd(5'h04, d); check("R11 held empty", d & 32'h0C, 32'h4);
        rd(5'h14, d);
        rd(5'h08, d); check("R6 rx underrun", d, 32'h2);
        wr(5'h08, 32'h1);
        rd(5'h08, d); check("R6 sticky other bit", d, 32'h2);
        wr(5'h08, 32'h2);
        rd(5'h08, d); check("R6 w1c rx", d, 32'h0);
        clean_up();
    endtask

    task automatic t_loopback();
        logic [31:0] d;
        wr(5'h0C, 32'h1);
        wr(5'h10, 32'hDEAD_BEEF);
        wr(5'h10, 32'h1234_8765);
        wr(5'h00, 32'h0000_300D);  // rx wm 3, rx irq, rx en, tx en
        check("R5 irq before frames", {31'h0, irq_o}, 32'h0);
        wait_cycles(150);
        rd(5'h04, d); check("R4 rx alert 2 free", d & 32'h32, 32'h02);
        check("R5 irq rx", {31'h0, irq_o}, 32'h1);
        rd(5'h08, d); check("R7 tx underrun", d, 32'h1);
        wr(5'h00, 32'h0);
        rd(5'h14, d); check("R9 loop word0", d, 32'hDEAD_BEEF);
        rd(5'h14, d); check("R9 loop word1", d, 32'h1234_8765);
        rd(5'h04, d); check("R2 rx empty", d & 32'h30, 32'h10);
        clean_up();
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        wr(5'h0C, 32'h1);
        wr(5'h00, 32'h0000_0004);
        wait_cycles(6 * 64 + 20);
        rd(5'h04, d); check("R2 rx full", d & 32'h30, 32'h20);
        rd(5'h08, d); check("R8 rx overrun", d, 32'h2);
        wr(5'h00, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd(5'h14, d); check("R7 zero frames", d, 32'h0);
        end
        rd(5'h04, d); check("R8 only 4 kept", d & 32'h30, 32'h10);
        clean_up();
    endtask

    task automatic t_bit_order();
        logic [31:0] dat, lr;
        wr(5'h0C, 32'h1);
        wr(5'h10, 32'hC3A5_5A3C);
        wr(5'h00, 32'h0000_0001);
        dat = '0; lr = '0;
        for (int i = 0; i < 32; i++) begin
            @(posedge bclk_o);
            #1;
            dat = {dat[30:0], ser_dout};
            lr  = {lr[30:0], lrclk_o};
        end
        wr(5'h00, 32'h0);
        check("R9 msb first", dat, 32'hC3A5_5A3C);
        check("R9 lr left low", lr, 32'h0000_FFFF);
        wait_cycles(2);
        check("R12 parked", {30'h0, bclk_o, lrclk_o}, 32'h0);
        clean_up();
    endtask

    task automatic t_divide();
        int n_hi, n_lo;
        wr(5'h0C, 32'h3);
        wr(5'h00, 32'h0000_0004);
        @(posedge bclk_o);
        n_hi = 0;
        forever begin
            @(negedge clk);
            if (bclk_o) n_hi++; else break;
        end
        n_lo = 1;
        forever begin
            @(negedge clk);
            if (!bclk_o) n_lo++; else break;
        end
        check("R10 high phase", n_hi, 3);
        check("R10 low phase", n_lo, 3);
        wr(5'h00, 32'h0);
        wait_cycles(1);
        check("R12 idle after disable", {30'h0, bclk_o, lrclk_o}, 32'h0);
        clean_up();
    endtask

    task automatic t_codec();
        wr(5'h00, 32'h0002_0000);
        check("R11 codec reset on", {31'h0, codec_rst_o}, 32'h1);
        wr(5'h00, 32'h0);
        check("R11 codec reset off", {31'h0, codec_rst_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_watermarks();
        t_loopback();
        t_overrun();
        t_bit_order();
        t_divide();
        t_codec();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule